// File: doc/BRIEF.md
# Serial NOR flash write-command engine

This block carries out the write-side commands of a serial NOR flash slave against a small internal byte array. A neighbouring shifter hands it the transaction one byte at a time: the first strobed byte of a transaction is the opcode, the next three are a big-endian address, and any further bytes are data. A one-cycle end pulse closes the transaction, and only at that pulse does the engine judge the byte count and update the array. Malformed transactions raise a one-cycle error flag and leave the array untouched.

The supported commands are page program, three erase granules, whole-array erase, and a two-bytes-per-transaction auto-increment program mode that keeps its own pointer. The write-enable latch comes from the status logic as an input and is sampled with the opcode. Each command kind can be removed by a parameter, and a removed command is ignored without error. A combinational read port exposes the array contents to the read path. The array depth and the erase granules are parameters (powers of two, array at most 64 KiB). They default to small values so that the whole array can be swept.

Top module: `fl_prog_engine`

## Requirements
- R1: After reset every array byte reads 0xFF, err_o is 0 and aai_o is 0.
- R2: The address is the three bytes after the opcode, most significant first, reduced modulo MEM_BYTES. Page program (opcode 0x02) writes data byte k to address (addr+k) mod MEM_BYTES, replacing the old value.
- R3: A page program with no data byte, or with more than MAX_PROG data bytes, raises err_o and changes no byte.
- R4: Sector erase (opcode 0x20) clears the address down to a multiple of SECT_BYTES and sets the SECT_BYTES bytes from there to 0xFF. No other byte changes.
- R5: Block erase works the same way with opcode 0x52 and granule BLK_S_BYTES, and with opcode 0xD8 and granule BLK_L_BYTES.
- R6: Whole-array erase (opcode 0x60 or 0xC7) sets every byte to 0xFF.
- R7: Sector and block erases must be exactly 4 bytes long and whole-array erase exactly 1 byte. Any other length raises err_o and changes no byte.
- R8: err_o is high for exactly the one cycle after the end pulse of a malformed transaction, and low otherwise.
- R9: When wel_in is 0 at the opcode byte, program, erase and auto-increment start transactions change nothing and raise no error.
- R10: Opcode 0xAD outside auto-increment mode must be exactly 6 bytes long. It writes data bytes 0 and 1 at addr and addr+1, sets aai_o, and sets the pointer to addr+2, all modulo MEM_BYTES. Any other length raises err_o and leaves aai_o at 0.
- R11: While aai_o is 1, opcode 0xAD must be exactly 3 bytes long. It writes its two data bytes at the pointer and at the pointer+1, and advances the pointer by 2 modulo MEM_BYTES, with no write-enable needed. A wrong length raises err_o and keeps the mode. Every opcode other than 0xAD and 0x04 is ignored in this mode.
- R12: Opcode 0x04 clears aai_o, whatever its length and whatever wel_in is.
- R13: A command kind whose enable parameter is 0 is ignored without error, whatever its length.
- R14: The array does not change before the end pulse, even when all bytes of a valid command have already been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | Strobe for one transaction byte on byte_in |
| byte_in | input | 8 | Transaction byte: opcode first, then address, then data |
| txn_end | input | 1 | One-cycle end of transaction pulse, never in the same cycle as byte_vld |
| wel_in | input | 1 | Write-enable latch from the status logic, sampled with the opcode |
| rd_addr | input | $clog2(MEM_BYTES) | Array read address |
| rd_data | output | 8 | Array byte at rd_addr (combinational) |
| err_o | output | 1 | Malformed-transaction pulse |
| aai_o | output | 1 | Auto-increment program mode active |

## Verification
The hardest state to reach is a chain of auto-increment transactions in which the pointer crosses the top of the array and wraps to address 0. Inside the same chain, a wrong-length continuation and a foreign erase opcode must both leave the mode and the pointer alone. The stimulus starts the chain three bytes below the top of the array. It then interleaves a short continuation and a sector erase with valid continuations, and sweeps the whole array after each one. Erase alignment is covered by an unaligned address in every granule of every size, each run against a freshly filled array. A second instance with some commands disabled receives the same byte stream.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam logic [7:0] OP_PAGE_PROG = 8'h02;
  localparam logic [7:0] OP_WR_DIS    = 8'h04;
  localparam logic [7:0] OP_SECT_ER   = 8'h20;
  localparam logic [7:0] OP_BLKS_ER   = 8'h52;
  localparam logic [7:0] OP_CHIP_ER_A = 8'h60;
  localparam logic [7:0] OP_AAI_PROG  = 8'hAD;
  localparam logic [7:0] OP_CHIP_ER_B = 8'hC7;
  localparam logic [7:0] OP_BLKL_ER   = 8'hD8;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_ERASE,
    ACT_PROG,
    ACT_AAI_GO,
    ACT_AAI_NEXT,
    ACT_AAI_STOP
  } act_e;
endpackage

// File: rtl/fl_frame_rx.sv
module fl_frame_rx #(
  parameter int AW    = 8,
  parameter int BUF_N = 4,
  parameter int CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_vld,
  input  logic [7:0]            byte_in,
  input  logic                  txn_end,
  input  logic                  wel_in,
  output logic [7:0]            op_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [AW-1:0]         addr_o,
  output logic [15:0]           pair_o,
  output logic [BUF_N-1:0][7:0] data_o,
  output logic                  wel_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [15:0] addr_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o   <= '0;
      op_o    <= '0;
      wel_o   <= 1'b0;
      addr_sh <= '0;
    end else if (txn_end) begin
      cnt_o <= '0;
    end else if (byte_vld) begin
      if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
      if (cnt_o == '0) begin
        op_o    <= byte_in;
        wel_o   <= wel_in;
        addr_sh <= '0;
      end else if (cnt_o <= CNT_W'(3)) begin
        addr_sh <= {addr_sh[7:0], byte_in};
      end
    end
  end

  for (genvar j = 0; j < BUF_N; j++) begin : g_data
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_o[j] <= '0;
      else if (byte_vld && !txn_end && cnt_o == CNT_W'(4 + j)) data_o[j] <= byte_in;
    end
  end

  assign addr_o = addr_sh[AW-1:0];
  assign pair_o = addr_sh;
endmodule

// File: rtl/fl_cmd_decode.sv
module fl_cmd_decode import fl_pkg::*; #(
  parameter int AW          = 8,
  parameter int CNT_W       = 4,
  parameter int MAX_PROG    = 4,
  parameter int SECT_BYTES  = 16,
  parameter int BLK_S_BYTES = 64,
  parameter int BLK_L_BYTES = 128,
  parameter bit EN_PROG     = 1,
  parameter bit EN_SECT     = 1,
  parameter bit EN_BLK_S    = 1,
  parameter bit EN_BLK_L    = 1,
  parameter bit EN_CHIP_A   = 1,
  parameter bit EN_CHIP_B   = 1,
  parameter bit EN_AAI      = 1
) (
  input  logic [7:0]       op,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wel,
  input  logic             aai_mode,
  output act_e             kind,
  output logic             err,
  output logic             er_all,
  output logic [AW-1:0]    er_mask
);
  localparam logic [AW-1:0] M_SECT  = AW'(SECT_BYTES - 1);
  localparam logic [AW-1:0] M_BLK_S = AW'(BLK_S_BYTES - 1);
  localparam logic [AW-1:0] M_BLK_L = AW'(BLK_L_BYTES - 1);

  function automatic logic prog_len_ok(input logic [CNT_W-1:0] n);
    return (n >= CNT_W'(5)) && (n <= CNT_W'(4 + MAX_PROG));
  endfunction

  always_comb begin
    kind    = ACT_NONE;
    err     = 1'b0;
    er_all  = 1'b0;
    er_mask = '0;
    if (cnt == '0) begin
      kind = ACT_NONE;
    end else if (aai_mode) begin
      if (op == OP_AAI_PROG) begin
        if (cnt == CNT_W'(3)) kind = ACT_AAI_NEXT;
        else err = 1'b1;
      end else if (op == OP_WR_DIS) begin
        kind = ACT_AAI_STOP;
      end
    end else if (wel) begin
      unique case (op)
        OP_PAGE_PROG: if (EN_PROG) begin
          if (prog_len_ok(cnt)) kind = ACT_PROG;
          else err = 1'b1;
        end
        OP_SECT_ER, OP_BLKS_ER, OP_BLKL_ER: begin
          if ((op == OP_SECT_ER && EN_SECT) || (op == OP_BLKS_ER && EN_BLK_S) ||
              (op == OP_BLKL_ER && EN_BLK_L)) begin
            er_mask = (op == OP_SECT_ER) ? M_SECT : (op == OP_BLKS_ER) ? M_BLK_S : M_BLK_L;
            if (cnt == CNT_W'(4)) kind = ACT_ERASE;
            else err = 1'b1;
          end
        end
        OP_CHIP_ER_A, OP_CHIP_ER_B: begin
          if ((op == OP_CHIP_ER_A && EN_CHIP_A) || (op == OP_CHIP_ER_B && EN_CHIP_B)) begin
            er_all = 1'b1;
            if (cnt == CNT_W'(1)) kind = ACT_ERASE;
            else err = 1'b1;
          end
        end
        OP_AAI_PROG: if (EN_AAI) begin
          if (cnt == CNT_W'(6)) kind = ACT_AAI_GO;
          else err = 1'b1;
        end
        default: kind = ACT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fl_mem_array.sv
module fl_mem_array #(
  parameter int MEM_BYTES = 256,
  parameter int BUF_N     = 4,
  parameter int AW        = 8,
  parameter int LW        = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  er_en,
  input  logic                  er_all,
  input  logic [AW-1:0]         er_base,
  input  logic [AW-1:0]         er_mask,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_base,
  input  logic [LW-1:0]         wr_len,
  input  logic [BUF_N-1:0][7:0] wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_data
);
  logic [7:0] mem [MEM_BYTES];

  function automatic logic in_granule(input logic [AW-1:0] idx, input logic [AW-1:0] base,
                                      input logic [AW-1:0] mask);
    return (idx & ~mask) == (base & ~mask);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (er_en) begin
      for (int i = 0; i < MEM_BYTES; i++)
        if (er_all || in_granule(AW'(i), er_base, er_mask)) mem[i] <= 8'hFF;
    end else if (wr_en) begin
      for (int k = 0; k < BUF_N; k++)
        if (LW'(k) < wr_len) mem[wr_base + AW'(k)] <= wr_data[k];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fl_prog_engine.sv
module fl_prog_engine import fl_pkg::*; #(
  parameter int MEM_BYTES   = 256,
  parameter int SECT_BYTES  = 16,
  parameter int BLK_S_BYTES = 64,
  parameter int BLK_L_BYTES = 128,
  parameter int MAX_PROG    = 4,
  parameter bit EN_PROG     = 1,
  parameter bit EN_SECT     = 1,
  parameter bit EN_BLK_S    = 1,
  parameter bit EN_BLK_L    = 1,
  parameter bit EN_CHIP_A   = 1,
  parameter bit EN_CHIP_B   = 1,
  parameter bit EN_AAI      = 1,
  localparam int AW         = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  input  logic          txn_end,
  input  logic          wel_in,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          err_o,
  output logic          aai_o
);
  localparam int BUF_N = (MAX_PROG < 2) ? 2 : MAX_PROG;
  localparam int CNT_W = $clog2(MAX_PROG + 6);
  localparam int LW    = $clog2(BUF_N + 1);

  logic [7:0]            f_op;
  logic [CNT_W-1:0]      f_cnt;
  logic [AW-1:0]         f_addr;
  logic [15:0]           f_pair;
  logic [BUF_N-1:0][7:0] f_data;
  logic                  f_wel;
  act_e                  kind;
  logic                  dec_err, er_all;
  logic [AW-1:0]         er_mask;
  logic                  aai_q;
  logic [AW-1:0]         aai_ptr;
  logic                  err_q;

  fl_frame_rx #(.AW(AW), .BUF_N(BUF_N), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in), .txn_end(txn_end),
    .wel_in(wel_in), .op_o(f_op), .cnt_o(f_cnt), .addr_o(f_addr), .pair_o(f_pair),
    .data_o(f_data), .wel_o(f_wel)
  );

  fl_cmd_decode #(
    .AW(AW), .CNT_W(CNT_W), .MAX_PROG(MAX_PROG), .SECT_BYTES(SECT_BYTES),
    .BLK_S_BYTES(BLK_S_BYTES), .BLK_L_BYTES(BLK_L_BYTES), .EN_PROG(EN_PROG),
    .EN_SECT(EN_SECT), .EN_BLK_S(EN_BLK_S), .EN_BLK_L(EN_BLK_L), .EN_CHIP_A(EN_CHIP_A),
    .EN_CHIP_B(EN_CHIP_B), .EN_AAI(EN_AAI)
  ) u_dec (
    .op(f_op), .cnt(f_cnt), .wel(f_wel), .aai_mode(aai_q), .kind(kind), .err(dec_err),
    .er_all(er_all), .er_mask(er_mask)
  );

  // Named commit events, visible to the checker.
  logic erase_evt, prog_evt, go_evt, cont_evt, stop_evt, bad_evt;
  assign erase_evt = txn_end && kind == ACT_ERASE;
  assign prog_evt  = txn_end && kind == ACT_PROG;
  assign go_evt    = txn_end && kind == ACT_AAI_GO;
  assign cont_evt  = txn_end && kind == ACT_AAI_NEXT;
  assign stop_evt  = txn_end && kind == ACT_AAI_STOP;
  assign bad_evt   = txn_end && dec_err;

  function automatic logic [AW-1:0] ptr_adv(input logic [AW-1:0] p);
    return p + AW'(2);
  endfunction

  logic [AW-1:0]         wr_base;
  logic [LW-1:0]         wr_len;
  logic [BUF_N-1:0][7:0] wr_data;

  always_comb begin
    wr_base = cont_evt ? aai_ptr : f_addr;
    wr_len  = prog_evt ? LW'(f_cnt - CNT_W'(4)) : LW'(2);
    wr_data = f_data;
    if (cont_evt) begin
      wr_data    = '0;
      wr_data[0] = f_pair[15:8];
      wr_data[1] = f_pair[7:0];
    end
  end

  fl_mem_array #(.MEM_BYTES(MEM_BYTES), .BUF_N(BUF_N), .AW(AW), .LW(LW)) u_mem (
    .clk(clk), .rst_n(rst_n), .er_en(erase_evt), .er_all(er_all), .er_base(f_addr),
    .er_mask(er_mask), .wr_en(prog_evt || go_evt || cont_evt), .wr_base(wr_base),
    .wr_len(wr_len), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aai_q   <= 1'b0;
      aai_ptr <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= bad_evt;
      if (go_evt) begin
        aai_q   <= 1'b1;
        aai_ptr <= ptr_adv(f_addr);
      end
      if (cont_evt) aai_ptr <= ptr_adv(aai_ptr);
      if (stop_evt) aai_q <= 1'b0;
    end
  end

  assign err_o = err_q;
  assign aai_o = aai_q;
endmodule

// File: rtl/fl_prog_engine_chk.sv
module fl_prog_engine_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txn_end,
  input logic          err_o,
  input logic          aai_o,
  input logic          cont_evt,
  input logic [AW-1:0] aai_ptr,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data
);
  // R8: an error pulse only ever follows an end pulse
  a_r8_err_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(txn_end));

  // R10: the mode is entered only at the end of a transaction
  a_r10_enter_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aai_o) |-> $past(txn_end));

  // R11: each continuation moves the pointer on by two
  a_r11_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    cont_evt |=> aai_ptr == $past(aai_ptr) + AW'(2));

  // R14: without an end pulse the array byte at a held address stays put
  a_r14_mem_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(txn_end) && rd_addr == $past(rd_addr)) |-> rd_data == $past(rd_data));
endmodule

bind fl_prog_engine fl_prog_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_end(txn_end), .err_o(err_o), .aai_o(aai_o),
  .cont_evt(cont_evt), .aai_ptr(aai_ptr), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/fl_prog_engine_tb.sv
module fl_prog_engine_tb;
  localparam int MEM = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_in = '0;
  logic       txn_end = 1'b0;
  logic       wel_in = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_a, rd_b;
  logic       err_a, err_b, aai_a, aai_b;

  always #2 clk = ~clk;

  fl_prog_engine u_dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in), .txn_end(txn_end),
    .wel_in(wel_in), .rd_addr(rd_addr), .rd_data(rd_a), .err_o(err_a), .aai_o(aai_a)
  );

  // Second instance: page program, sector erase and opcode 0xC7 removed.
  fl_prog_engine #(.EN_PROG(0), .EN_SECT(0), .EN_CHIP_B(0)) u_dis (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in), .txn_end(txn_end),
    .wel_in(wel_in), .rd_addr(rd_addr), .rd_data(rd_b), .err_o(err_b), .aai_o(aai_b)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] tx [16];
  logic [7:0] em [2][MEM];
  bit         eaai [2];
  int         eptr [2];
  bit         eerr [2];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sweep(input string tag);
    int bad_a = 0, bad_b = 0, fa = 0, fe = 0, fb = 0, fbe = 0;
    for (int i = 0; i < MEM; i++) begin
      rd_addr = 8'(i);
      #1;
      if (rd_a !== em[0][i]) begin if (bad_a == 0) begin fa = rd_a; fe = em[0][i]; end bad_a++; end
      if (rd_b !== em[1][i]) begin if (bad_b == 0) begin fb = rd_b; fbe = em[1][i]; end bad_b++; end
    end
    check(bad_a == 0, {tag, " array u_dut"}, fa, fe);
    check(bad_b == 0, {tag, " array u_dis"}, fb, fbe);
  endtask

  // Expected effect of the transaction in tx[0..n-1] on instance s.
  task automatic model(input int s, input int n, input bit wel);
    bit en_prog = (s == 0), en_sect = (s == 0), en_c7 = (s == 0);
    int a, g, base;
    eerr[s] = 0;
    if (n == 0) return;
    a = ((int'(tx[1]) << 16) | (int'(tx[2]) << 8) | int'(tx[3])) % MEM;
    if (eaai[s]) begin
      if (tx[0] == 8'hAD) begin
        if (n == 3) begin
          em[s][eptr[s]] = tx[1];
          em[s][(eptr[s] + 1) % MEM] = tx[2];
          eptr[s] = (eptr[s] + 2) % MEM;
        end else eerr[s] = 1;
      end else if (tx[0] == 8'h04) eaai[s] = 0;
      return;
    end
    if (!wel) return;
    case (tx[0])
      8'h02: if (en_prog) begin
        if (n < 5 || n - 4 > 4) eerr[s] = 1;
        else for (int k = 0; k < n - 4; k++) em[s][(a + k) % MEM] = tx[4 + k];
      end
      8'h20, 8'h52, 8'hD8: if (tx[0] != 8'h20 || en_sect) begin
        g = (tx[0] == 8'h20) ? 16 : (tx[0] == 8'h52) ? 64 : 128;
        if (n != 4) eerr[s] = 1;
        else begin
          base = (a / g) * g;
          for (int k = 0; k < g; k++) em[s][base + k] = 8'hFF;
        end
      end
      8'h60, 8'hC7: if (tx[0] != 8'hC7 || en_c7) begin
        if (n != 1) eerr[s] = 1;
        else for (int k = 0; k < MEM; k++) em[s][k] = 8'hFF;
      end
      8'hAD: begin
        if (n != 6) eerr[s] = 1;
        else begin
          em[s][a] = tx[4];
          em[s][(a + 1) % MEM] = tx[5];
          eptr[s] = (a + 2) % MEM;
          eaai[s] = 1;
        end
      end
      default: ;
    endcase
  endtask

  task automatic txn(input int n, input bit wel, input string tag, input bit do_sweep,
                     input bit mid);
    wel_in = wel;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      byte_vld = 1'b1;
      byte_in  = tx[k];
    end
    @(negedge clk);
    byte_vld = 1'b0;
    wel_in   = 1'b0;
    if (mid) sweep({tag, " before end"});
    @(negedge clk);
    txn_end = 1'b1;
    @(negedge clk);
    txn_end = 1'b0;
    model(0, n, wel);
    model(1, n, wel);
    check(err_a === eerr[0], {tag, " err u_dut"}, err_a, eerr[0]);
    check(err_b === eerr[1], {tag, " err u_dis"}, err_b, eerr[1]);
    check(aai_a === eaai[0], {tag, " mode u_dut"}, aai_a, eaai[0]);
    check(aai_b === eaai[1], {tag, " mode u_dis"}, aai_b, eaai[1]);
    if (do_sweep) sweep(tag);
  endtask

  task automatic set4(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input logic [7:0] b3);
    tx[0] = b0; tx[1] = b1; tx[2] = b2; tx[3] = b3;
  endtask

  // Fill both arrays with a non-erased pattern through 4-byte page programs.
  task automatic fill(input int seed);
    for (int blk = 0; blk < MEM / 4; blk++) begin
      set4(8'h02, 8'h00, 8'h00, 8'(blk * 4));
      for (int k = 0; k < 4; k++) tx[4 + k] = 8'((blk * 4 + k) * 5 + seed);
      txn(8, 1'b1, "R2 fill", 1'b0, 1'b0);
    end
    // The disabled instance keeps 0xFF from a whole-array erase; refill it is impossible,
    // so its model simply stays as computed.
  endtask

  initial begin
    #(4 * 180000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < MEM; i++) em[s][i] = 8'hFF;
      eaai[s] = 0; eptr[s] = 0; eerr[s] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(err_a === 1'b0 && aai_a === 1'b0, "R1 flags in reset", {err_a, aai_a}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(err_a === 1'b0 && aai_a === 1'b0, "R1 flags after reset", {err_a, aai_a}, 0);
    sweep("R1 erased after reset");

    // R2/R3/R14: program lengths 0..5 data bytes, high address bytes dropped, wrap at top.
    for (int len = 0; len <= 5; len++) begin
      set4(8'h02, 8'h12, 8'h34, 8'hFE);
      for (int k = 0; k < len; k++) tx[4 + k] = 8'(8'h30 + len * 8 + k);
      txn(4 + len, 1'b1, (len == 0 || len == 5) ? "R3 length" : "R2 wrap", 1'b1, len == 3);
    end
    // R9: no write enable
    set4(8'h02, 8'h00, 8'h00, 8'h40); tx[4] = 8'h11; tx[5] = 8'h22;
    txn(6, 1'b0, "R9 program no wel", 1'b1, 1'b0);
    set4(8'h02, 8'h00, 8'h00, 8'h40); tx[4] = 8'h00;
    txn(3, 1'b0, "R9 bad length no wel", 1'b0, 1'b0);

    // R4/R5: every granule of each erase size, unaligned address, fresh fill each time.
    for (int op = 0; op < 3; op++) begin
      int g = (op == 0) ? 16 : (op == 1) ? 64 : 128;
      logic [7:0] opc = (op == 0) ? 8'h20 : (op == 1) ? 8'h52 : 8'hD8;
      for (int gi = 0; gi < MEM / g; gi++) begin
        fill(gi + op * 17);
        set4(opc, 8'hA5, 8'h00, 8'(gi * g + g / 2 + 1));
        txn(4, 1'b1, (op == 0) ? "R4 sector erase" : "R5 block erase", 1'b1, 1'b0);
      end
    end

    // R7: wrong erase lengths change nothing
    fill(3);
    set4(8'h52, 8'h00, 8'h00, 8'h10);
    txn(3, 1'b1, "R7 erase short", 1'b1, 1'b0);
    tx[4] = 8'h00;
    txn(5, 1'b1, "R7 erase long", 1'b1, 1'b0);
    set4(8'h60, 8'h00, 8'h00, 8'h00);
    txn(2, 1'b1, "R7 chip erase long", 1'b1, 1'b0);
    // R8: the error pulse lasts one cycle only
    @(negedge clk);
    check(err_a === 1'b0, "R8 error pulse width", err_a, 0);
    // R13: disabled sector erase with wrong length: u_dis silent
    set4(8'h20, 8'h00, 8'h00, 8'h00);
    txn(2, 1'b1, "R13 disabled kind", 1'b1, 1'b0);

    // R6/R13: whole-array erase both opcodes
    set4(8'hC7, 8'h00, 8'h00, 8'h00);
    txn(1, 1'b1, "R6 erase C7", 1'b1, 1'b0);
    fill(9);
    set4(8'h60, 8'h00, 8'h00, 8'h00);
    txn(1, 1'b1, "R6 erase 60", 1'b1, 1'b0);

    // R10/R11/R12: auto-increment chain across the top of the array
    set4(8'hAD, 8'h00, 8'h00, 8'hFD); tx[4] = 8'hA1;
    txn(5, 1'b1, "R10 start short", 1'b1, 1'b0);
    set4(8'hAD, 8'h00, 8'h00, 8'hFD); tx[4] = 8'hA1; tx[5] = 8'hA2;
    txn(6, 1'b0, "R9 start no wel", 1'b1, 1'b0);
    txn(6, 1'b1, "R10 start", 1'b1, 1'b0);
    set4(8'hAD, 8'hB1, 8'hB2, 8'h00);
    txn(3, 1'b0, "R11 wrap continuation", 1'b1, 1'b0);
    txn(2, 1'b0, "R11 short continuation", 1'b1, 1'b0);
    set4(8'h20, 8'h00, 8'h00, 8'h00);
    txn(4, 1'b1, "R11 foreign opcode", 1'b1, 1'b0);
    set4(8'hAD, 8'hC1, 8'hC2, 8'h00);
    txn(3, 1'b0, "R11 continuation", 1'b1, 1'b0);
    set4(8'h04, 8'h00, 8'h00, 8'h00);
    txn(1, 1'b0, "R12 exit", 1'b1, 1'b0);
    set4(8'hAD, 8'hD1, 8'hD2, 8'h00);
    txn(3, 1'b1, "R12 after exit", 1'b1, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule